// File: doc/BRIEF.md
# External Interrupt Request Detector

This block watches sixteen maskable external interrupt inputs and one nonmaskable input. It turns activity on them into interrupt requests for a CPU interrupt controller. Each maskable line has a two-bit sense setting, an enable bit and a status flag. Software reads these over a small register bus and clears a flag by writing 0 to its bit. The upper ten lines can take their input from either a main pin or an alternate pin.

The nonmaskable input has one control bit that selects its active edge. A detected edge produces a one-cycle request that no enable affects. The block outputs the per-line requests and the index of the highest-priority pending request. It also outputs a wake-up signal that is high whenever any request, maskable or not, is present. Every pin goes through a two-flop synchronizer. Edges are found by comparing the synchronized value with its value one cycle earlier.

The asynchronous reset input is released synchronously inside the block. All register addresses below are word addresses on `bus_addr`.

Top module: `extirq_detector`

## Requirements
- R1: After reset, every register reads 0, and `irq_req`, `irq_any`, `nmi_req` and `wake` are 0. Unused addresses 6 and 7 read 0.
- R2: Sense code 2'b00 (low level): a line's flag is set while its synchronized input is low. A clearing write made while the input is still low has no effect. The flag stays set after the input returns high, until software clears it.
- R3: Sense code 2'b01 (falling edge) sets the flag on a high-to-low transition only. The flag and request become visible on the third rising clock edge after the pin changes. Line n's sense code sits at bits [2n+1:2n] of address 0 for n < 8, and at bits [2(n-8)+1:2(n-8)] of address 1 for n >= 8.
- R4: Sense code 2'b10 (rising edge) sets the flag on a low-to-high transition only.
- R5: Sense code 2'b11 sets the flag on either transition.
- R6: The status register at address 3 has bit n for line n. A write clears the flags whose data bits are 0 and leaves the flags whose data bits are 1 unchanged.
- R7: `irq_req[n]` is high exactly when flag n and enable bit n (address 2, bit n) are both 1. A flag still sets while its line is disabled.
- R8: `irq_any` is high when any `irq_req` bit is set. `irq_vec` then gives the lowest-numbered set request.
- R9: Bit n of the alternate-select register (address 4) selects `pin_alt[n-6]` instead of `pin_main[n]` for lines 6 to 15. Bits 0 to 5 read 0 and have no effect. A deselected pin has no effect.
- R10: Bit 0 of address 5 selects the nonmaskable active edge: 1 for rising, 0 for falling. A matching edge gives a one-cycle `nmi_req` pulse on the third rising clock edge after the pin changes. The pulse does not depend on any enable bit.
- R11: `wake` is high exactly when `nmi_req` is high or any `irq_req` bit is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from `bus_addr` |
| pin_main | input | 16 | Main interrupt pins, one per line |
| pin_alt | input | 10 | Alternate pins for lines 6 to 15 |
| pin_nmi | input | 1 | Nonmaskable interrupt pin |
| irq_req | output | 16 | Per-line requests (flag and enable) |
| irq_any | output | 1 | At least one maskable request is pending |
| irq_vec | output | 4 | Index of the lowest-numbered pending request |
| nmi_req | output | 1 | One-cycle nonmaskable request pulse |
| wake | output | 1 | Wake-up indication |

## Verification
The one-cycle check on `nmi_req` assumes the nonmaskable edge select is not changed while that pin is moving. A change of that bit could let a rising and a falling edge on consecutive cycles each produce a pulse. The bench changes the edge bit only while `pin_nmi` has been stable for several cycles. It holds every pin level for at least four cycles, so each transition is seen once by the synchronizer. It switches an alternate-select bit only while both candidate pins are high, so the source change itself creates no edge.

// File: rtl/extirq_pkg.sv
package extirq_pkg;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_FALL = 2'b01,
    SENSE_RISE = 2'b10,
    SENSE_BOTH = 2'b11
  } sense_e;

  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_SENSE_LO = 3'd0;
  localparam logic [ADDR_W-1:0] A_SENSE_HI = 3'd1;
  localparam logic [ADDR_W-1:0] A_ENABLE   = 3'd2;
  localparam logic [ADDR_W-1:0] A_STATUS   = 3'd3;
  localparam logic [ADDR_W-1:0] A_ALTSEL   = 3'd4;
  localparam logic [ADDR_W-1:0] A_NMICTL   = 3'd5;

endpackage

// File: rtl/extirq_sync.sv
module extirq_sync #(
  parameter int   WIDTH   = 1,
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] sync_o,
  output logic [WIDTH-1:0] prev_o
);

  localparam logic [WIDTH-1:0] IDLE = {WIDTH{RST_VAL}};

  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];
  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] prev_d;

  always_comb begin
    stage_d[0] = din;
    for (int s = 1; s < STAGES; s++) begin
      stage_d[s] = stage_q[s-1];
    end
    prev_d = stage_q[STAGES-1];
  end

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[s] <= IDLE;
      end else begin
        stage_q[s] <= stage_d[s];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= IDLE;
    end else begin
      prev_q <= prev_d;
    end
  end

  assign sync_o = stage_q[STAGES-1];
  assign prev_o = prev_q;

endmodule

// File: rtl/extirq_cond.sv
module extirq_cond
  import extirq_pkg::*;
#(
  parameter int NUM_LINES = 16
) (
  input  logic [2*NUM_LINES-1:0] sense_cfg,
  input  logic [NUM_LINES-1:0]   sync_i,
  input  logic [NUM_LINES-1:0]   prev_i,
  output logic [NUM_LINES-1:0]   hit_o
);

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    sense_e mode;
    assign mode = sense_e'(sense_cfg[2*i +: 2]);

    always_comb begin
      unique case (mode)
        SENSE_LOW:  hit_o[i] = ~sync_i[i];
        SENSE_FALL: hit_o[i] = prev_i[i] & ~sync_i[i];
        SENSE_RISE: hit_o[i] = ~prev_i[i] & sync_i[i];
        SENSE_BOTH: hit_o[i] = prev_i[i] ^ sync_i[i];
        default:    hit_o[i] = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/extirq_regs.sv
module extirq_regs
  import extirq_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int ALT_BASE  = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_en,
  input  logic                   bus_we,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [NUM_LINES-1:0]   bus_wdata,
  output logic [NUM_LINES-1:0]   bus_rdata,
  input  logic [NUM_LINES-1:0]   hit,
  output logic [2*NUM_LINES-1:0] sense_cfg,
  output logic [NUM_LINES-1:0]   enable,
  output logic [NUM_LINES-1:0]   flags,
  output logic [NUM_LINES-1:0]   alt_sel,
  output logic                   nmi_rise
);

  localparam logic [NUM_LINES-1:0] ALT_MASK = {NUM_LINES{1'b1}} << ALT_BASE;

  logic [NUM_LINES-1:0] sense_lo_q, sense_hi_q, enable_q, flags_q, alt_q;
  logic [NUM_LINES-1:0] flags_d, alt_d;
  logic                 nmi_rise_q;
  logic                 wr;
  logic                 sense_lo_en, sense_hi_en, enable_en, alt_en, nmi_en;

  assign wr = bus_en & bus_we;

  // next-state decode
  always_comb begin
    sense_lo_en = wr && (bus_addr == A_SENSE_LO);
    sense_hi_en = wr && (bus_addr == A_SENSE_HI);
    enable_en   = wr && (bus_addr == A_ENABLE);
    alt_en      = wr && (bus_addr == A_ALTSEL);
    nmi_en      = wr && (bus_addr == A_NMICTL);
    alt_d       = bus_wdata & ALT_MASK;
    if (wr && (bus_addr == A_STATUS)) begin
      flags_d = (flags_q & bus_wdata) | hit;
    end else begin
      flags_d = flags_q | hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense_lo_q <= '0;
      sense_hi_q <= '0;
      enable_q   <= '0;
      flags_q    <= '0;
      alt_q      <= '0;
      nmi_rise_q <= 1'b0;
    end else begin
      if (sense_lo_en) sense_lo_q <= bus_wdata;
      if (sense_hi_en) sense_hi_q <= bus_wdata;
      if (enable_en)   enable_q   <= bus_wdata;
      if (alt_en)      alt_q      <= alt_d;
      if (nmi_en)      nmi_rise_q <= bus_wdata[0];
      flags_q <= flags_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_SENSE_LO: bus_rdata = sense_lo_q;
      A_SENSE_HI: bus_rdata = sense_hi_q;
      A_ENABLE:   bus_rdata = enable_q;
      A_STATUS:   bus_rdata = flags_q;
      A_ALTSEL:   bus_rdata = alt_q;
      A_NMICTL:   bus_rdata = {{(NUM_LINES-1){1'b0}}, nmi_rise_q};
      default:    bus_rdata = '0;
    endcase
  end

  assign sense_cfg = {sense_hi_q, sense_lo_q};
  assign enable    = enable_q;
  assign flags     = flags_q;
  assign alt_sel   = alt_q;
  assign nmi_rise  = nmi_rise_q;

endmodule

// File: rtl/extirq_prio.sv
module extirq_prio #(
  parameter int NUM_LINES = 16,
  localparam int VEC_W = $clog2(NUM_LINES)
) (
  input  logic [NUM_LINES-1:0] req,
  output logic                 any,
  output logic [VEC_W-1:0]     idx
);

  // scan from the top so the lowest-numbered request is the last to land
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = VEC_W'(i);
      end
    end
  end

endmodule

// File: rtl/extirq_detector.sv
module extirq_detector
  import extirq_pkg::*;
#(
  parameter int NUM_LINES   = 16,
  parameter int ALT_BASE    = 6,
  parameter int SYNC_STAGES = 2,
  localparam int VEC_W = $clog2(NUM_LINES),
  localparam int ALT_W = NUM_LINES - ALT_BASE
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_en,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [NUM_LINES-1:0] bus_wdata,
  output logic [NUM_LINES-1:0] bus_rdata,
  input  logic [NUM_LINES-1:0] pin_main,
  input  logic [ALT_W-1:0]     pin_alt,
  input  logic                 pin_nmi,
  output logic [NUM_LINES-1:0] irq_req,
  output logic                 irq_any,
  output logic [VEC_W-1:0]     irq_vec,
  output logic                 nmi_req,
  output logic                 wake
);

  // reset: asserted at once, released after two clocks
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic [2*NUM_LINES-1:0] sense_cfg;
  logic [NUM_LINES-1:0]   line_en, line_flag, alt_sel;
  logic [NUM_LINES-1:0]   line_src, line_sync, line_prev, line_hit;
  logic                   nmi_rise;

  // pin source selection
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_src
    if (i >= ALT_BASE) begin : g_alt
      assign line_src[i] = alt_sel[i] ? pin_alt[i-ALT_BASE] : pin_main[i];
    end else begin : g_main
      assign line_src[i] = pin_main[i];
    end
  end

  extirq_sync #(
    .WIDTH  (NUM_LINES),
    .STAGES (SYNC_STAGES),
    .RST_VAL(1'b1)
  ) u_line_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .din   (line_src),
    .sync_o(line_sync),
    .prev_o(line_prev)
  );

  extirq_cond #(.NUM_LINES(NUM_LINES)) u_cond (
    .sense_cfg(sense_cfg),
    .sync_i   (line_sync),
    .prev_i   (line_prev),
    .hit_o    (line_hit)
  );

  extirq_regs #(
    .NUM_LINES(NUM_LINES),
    .ALT_BASE (ALT_BASE)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .bus_en   (bus_en),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .hit      (line_hit),
    .sense_cfg(sense_cfg),
    .enable   (line_en),
    .flags    (line_flag),
    .alt_sel  (alt_sel),
    .nmi_rise (nmi_rise)
  );

  assign irq_req = line_flag & line_en;

  extirq_prio #(.NUM_LINES(NUM_LINES)) u_prio (
    .req(irq_req),
    .any(irq_any),
    .idx(irq_vec)
  );

  // nonmaskable path
  logic nmi_sync, nmi_prev, nmi_hit, nmi_req_q;

  extirq_sync #(
    .WIDTH  (1),
    .STAGES (SYNC_STAGES),
    .RST_VAL(1'b1)
  ) u_nmi_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .din   (pin_nmi),
    .sync_o(nmi_sync),
    .prev_o(nmi_prev)
  );

  assign nmi_hit = nmi_rise ? (~nmi_prev & nmi_sync) : (nmi_prev & ~nmi_sync);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      nmi_req_q <= 1'b0;
    end else begin
      nmi_req_q <= nmi_hit;
    end
  end

  assign nmi_req = nmi_req_q;
  assign wake    = nmi_req_q | (|irq_req);

endmodule

// File: rtl/extirq_detector_chk.sv
module extirq_detector_chk
  import extirq_pkg::*;
#(
  parameter int NUM_LINES = 16,
  localparam int VEC_W = $clog2(NUM_LINES)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NUM_LINES-1:0]   irq_req,
  input logic                   irq_any,
  input logic [VEC_W-1:0]       irq_vec,
  input logic                   nmi_req,
  input logic                   wake,
  input logic [NUM_LINES-1:0]   line_flag,
  input logic [2*NUM_LINES-1:0] sense_cfg,
  input logic [NUM_LINES-1:0]   line_sync
);

  // R8
  vec_points_at_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_any |-> irq_req[irq_vec]);

  // R8
  vec_is_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_any |-> ((irq_req & ~({NUM_LINES{1'b1}} << irq_vec)) == '0));

  // R8
  any_matches_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_any |-> (irq_req == '0));

  // R11
  wake_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake == (nmi_req || (irq_req != '0)));

  // R10
  nmi_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |=> !nmi_req);

  // R2
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_lvl
    level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((sense_cfg[2*i +: 2] == SENSE_LOW) && !line_sync[i]) |=> line_flag[i]);
  end

endmodule

bind extirq_detector extirq_detector_chk #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .irq_req  (irq_req),
  .irq_any  (irq_any),
  .irq_vec  (irq_vec),
  .nmi_req  (nmi_req),
  .wake     (wake),
  .line_flag(line_flag),
  .sense_cfg(sense_cfg),
  .line_sync(line_sync)
);

// File: tb/extirq_detector_bench.sv
module extirq_detector_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [15:0] pin_main = 16'hFFFF;
  logic [9:0]  pin_alt = 10'h3FF;
  logic        pin_nmi = 1'b1;
  logic [15:0] irq_req;
  logic        irq_any;
  logic [3:0]  irq_vec;
  logic        nmi_req;
  logic        wake;

  int checks = 0;
  int errors = 0;
  int nmi_cnt = 0;

  always #5 clk = ~clk;

  extirq_detector u_extirq_detector (
    .clk(clk), .rst_n(rst_n),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_main(pin_main), .pin_alt(pin_alt), .pin_nmi(pin_nmi),
    .irq_req(irq_req), .irq_any(irq_any), .irq_vec(irq_vec),
    .nmi_req(nmi_req), .wake(wake)
  );

  always @(negedge clk) if (nmi_req) nmi_cnt++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_en = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic expect_reg(input string req, input logic [2:0] a, input logic [15:0] exp);
    logic [15:0] v;
    bus_read(a, v);
    chk(req, {16'h0, v}, {16'h0, exp});
  endtask

  task automatic t_reset();
    for (int a = 0; a < 8; a++) expect_reg("R1 reg", 3'(a), 16'h0000);
    chk("R1 irq_req", {16'h0, irq_req}, 32'h0);
    chk("R1 irq_any", {31'h0, irq_any}, 32'h0);
    chk("R1 nmi_req", {31'h0, nmi_req}, 32'h0);
    chk("R1 wake", {31'h0, wake}, 32'h0);
  endtask

  task automatic t_fall();
    bus_write(3'd0, 16'h0010);
    bus_write(3'd2, 16'h0004);
    pin_main[2] = 1'b0;
    repeat (2) @(posedge clk);
    #1 chk("R3 not yet", {16'h0, irq_req}, 32'h0);
    @(posedge clk);
    #1 chk("R3 latency", {16'h0, irq_req}, 32'h0004);
    chk("R8 vec", {28'h0, irq_vec}, 32'd2);
    chk("R11 wake", {31'h0, wake}, 32'h1);
    bus_write(3'd3, 16'hFFFB);
    expect_reg("R3 cleared", 3'd3, 16'h0000);
    pin_main[2] = 1'b1;
    settle();
    expect_reg("R3 rise ignored", 3'd3, 16'h0000);
    bus_write(3'd2, 16'h0000);
    bus_write(3'd0, 16'h0000);
  endtask

  task automatic t_rise();
    bus_write(3'd0, 16'h0200);
    pin_main[4] = 1'b0;
    settle();
    expect_reg("R4 fall ignored", 3'd3, 16'h0000);
    pin_main[4] = 1'b1;
    settle();
    expect_reg("R4 rise", 3'd3, 16'h0010);
    bus_write(3'd3, 16'h0000);
    bus_write(3'd0, 16'h0000);
  endtask

  task automatic t_both();
    bus_write(3'd0, 16'h0003);
    pin_main[0] = 1'b0;
    settle();
    expect_reg("R5 fall", 3'd3, 16'h0001);
    bus_write(3'd3, 16'h0000);
    expect_reg("R5 cleared", 3'd3, 16'h0000);
    pin_main[0] = 1'b1;
    settle();
    expect_reg("R5 rise", 3'd3, 16'h0001);
    bus_write(3'd3, 16'h0000);
    bus_write(3'd0, 16'h0000);
  endtask

  task automatic t_level();
    pin_main[1] = 1'b0;
    settle();
    expect_reg("R2 set", 3'd3, 16'h0002);
    bus_write(3'd3, 16'h0000);
    expect_reg("R2 clear while low", 3'd3, 16'h0002);
    pin_main[1] = 1'b1;
    settle();
    expect_reg("R2 held after high", 3'd3, 16'h0002);
    bus_write(3'd3, 16'h0000);
    expect_reg("R2 cleared", 3'd3, 16'h0000);
  endtask

  task automatic t_w0c();
    bus_write(3'd0, 16'h0410);
    pin_main[2] = 1'b0; pin_main[5] = 1'b0;
    settle();
    pin_main[2] = 1'b1; pin_main[5] = 1'b1;
    settle();
    expect_reg("R6 set", 3'd3, 16'h0024);
    bus_write(3'd3, 16'hFFFF);
    expect_reg("R6 ones keep", 3'd3, 16'h0024);
    bus_write(3'd3, 16'hFFFB);
    expect_reg("R6 zero clears", 3'd3, 16'h0020);
    bus_write(3'd3, 16'h0000);
    bus_write(3'd0, 16'h0000);
  endtask

  task automatic t_enable();
    bus_write(3'd0, 16'h0040);
    pin_main[3] = 1'b0;
    settle();
    pin_main[3] = 1'b1;
    settle();
    expect_reg("R7 flag while off", 3'd3, 16'h0008);
    chk("R7 no req", {16'h0, irq_req}, 32'h0);
    chk("R11 no wake", {31'h0, wake}, 32'h0);
    bus_write(3'd2, 16'h0008);
    chk("R7 req", {16'h0, irq_req}, 32'h0008);
    chk("R11 wake", {31'h0, wake}, 32'h1);
    bus_write(3'd2, 16'h0000);
    bus_write(3'd3, 16'h0000);
    bus_write(3'd0, 16'h0000);
  endtask

  task automatic t_prio();
    bus_write(3'd0, 16'h0440);
    bus_write(3'd1, 16'h0100);
    bus_write(3'd2, 16'h1028);
    pin_main[3] = 1'b0; pin_main[5] = 1'b0; pin_main[12] = 1'b0;
    settle();
    pin_main[3] = 1'b1; pin_main[5] = 1'b1; pin_main[12] = 1'b1;
    settle();
    chk("R8 any", {31'h0, irq_any}, 32'h1);
    chk("R8 vec3", {28'h0, irq_vec}, 32'd3);
    bus_write(3'd3, 16'hFFF7);
    chk("R8 vec5", {28'h0, irq_vec}, 32'd5);
    bus_write(3'd3, 16'hFFDF);
    chk("R8 vec12", {28'h0, irq_vec}, 32'd12);
    bus_write(3'd3, 16'h0000);
    chk("R8 none", {31'h0, irq_any}, 32'h0);
    bus_write(3'd2, 16'h0000);
    bus_write(3'd1, 16'h0000);
    bus_write(3'd0, 16'h0000);
  endtask

  task automatic t_alt();
    bus_write(3'd4, 16'hFFFF);
    expect_reg("R9 low bits zero", 3'd4, 16'hFFC0);
    bus_write(3'd4, 16'h0080);
    bus_write(3'd0, 16'h4000);
    pin_main[7] = 1'b0;
    settle();
    expect_reg("R9 main ignored", 3'd3, 16'h0000);
    pin_main[7] = 1'b1;
    settle();
    pin_alt[1] = 1'b0;
    settle();
    expect_reg("R9 alt used", 3'd3, 16'h0080);
    pin_alt[1] = 1'b1;
    settle();
    bus_write(3'd3, 16'h0000);
    bus_write(3'd0, 16'h0000);
    bus_write(3'd4, 16'h0000);
  endtask

  task automatic t_nmi();
    int base;
    base = nmi_cnt;
    pin_nmi = 1'b0;
    repeat (2) @(posedge clk);
    #1 chk("R10 not yet", {31'h0, nmi_req}, 32'h0);
    @(posedge clk);
    #1 chk("R10 pulse", {31'h0, nmi_req}, 32'h1);
    chk("R11 wake nmi", {31'h0, wake}, 32'h1);
    @(posedge clk);
    #1 chk("R10 one cycle", {31'h0, nmi_req}, 32'h0);
    pin_nmi = 1'b1;
    settle();
    chk("R10 falling mode count", nmi_cnt, base + 1);
    bus_write(3'd5, 16'h0001);
    expect_reg("R10 ctl", 3'd5, 16'h0001);
    pin_nmi = 1'b0;
    settle();
    chk("R10 fall ignored", nmi_cnt, base + 1);
    pin_nmi = 1'b1;
    settle();
    chk("R10 rise count", nmi_cnt, base + 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_fall();
    t_rise();
    t_both();
    t_level();
    t_w0c();
    t_enable();
    t_prio();
    t_alt();
    t_nmi();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule